// File: doc/BRIEF.md
# SDRAM Burst Read Output Pipeline

This block models the device side of a synchronous DRAM read data path. It takes commands that are already decoded: NOP, READ with a bank and a start column, WRITE, and PRECHARGE with a bank or an all-banks flag. The burst length, burst order and CAS latency come from mode inputs that were programmed earlier and are held stable. A READ does not carry them. The block also takes a per-cycle data-mask input.

On each cycle of a burst the block computes the next column. It reads the word for that column from a computed array stub and lines the word up with the selected CAS latency. It drives the word on the data output together with a registered output-enable. When the enable is low, the data pins are taken as high impedance.

A burst ends in one of four ways. It runs out at its programmed length. It is replaced by a new READ. It is stopped by a matching precharge. It is killed by a WRITE. Full-page bursts run until one of the last three happens.

Top module: `sdram_rd_pipe`

## Requirements
- R1: While rst_ni is low, dq_oe_o is low and dq_o is zero.
- R2: A READ (cmd_i code 1) sampled at clock edge k puts its first word on dq_o, with dq_oe_o high, in the cycle after edge k+L. L is cas_lat_i (1, 2 or 3), and code 0 acts as 1. Later words follow one per cycle.
- R3: A word read from bank b, column c equals the value {b,c}, zero-extended to DATA_W bits, XOR SEED (default 16'hA5C3). dq_o is zero on every cycle where dq_oe_o is low.
- R4: burst_len_i sets the burst length N: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 8, and code 7 gives a full page. Codes 4 to 6 act as 1. A fixed-length burst with no later command delivers exactly N words. dq_oe_o is low on the next cycle.
- R5: With burst_type_i = 0 (sequential), word i uses column base + ((start + i) mod N). Here base is the start column rounded down to a multiple of N.
- R6: With burst_type_i = 1 (interleaved), word i uses column base + ((start mod N) XOR i).
- R7: A full-page burst uses column (start + i) mod 2^COL_W. It wraps from the last column to column 0 and runs until it is terminated. burst_type_i has no effect on it.
- R8: dqm_i high at edge n forces dq_oe_o low, and dq_o to zero, in the cycle after edge n+2 only. The burst keeps advancing, so the masked word is skipped and is not delayed.
- R9: A READ sampled while a burst is active may come on any cycle. The old burst issues no further words. The first word of the new burst appears L cycles after its READ, directly after the words the old burst had already issued.
- R10: A PRECHARGE (code 3) with all_banks_i high, or with bank_i equal to the bank being read, stops the burst at the edge where it is sampled. Only the words issued before that edge still appear. A PRECHARGE to another bank with all_banks_i low has no effect.
- R11: A WRITE (code 2) sampled at edge w drops every pending word. dq_oe_o stays low from edge w until the data of a later READ arrives. If dqm_i was high at edge w-3, dq_oe_o is also low during the cycle in which the WRITE is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 0 NOP, 1 READ, 2 WRITE, 3 PRECHARGE |
| bank_i | input | BANK_W | Bank for READ or PRECHARGE |
| col_i | input | COL_W | Start column for READ |
| all_banks_i | input | 1 | PRECHARGE applies to every bank |
| burst_len_i | input | 3 | Burst length code |
| burst_type_i | input | 1 | 0 sequential, 1 interleaved |
| cas_lat_i | input | 2 | CAS latency 1 to 3 |
| dqm_i | input | 1 | Data mask, two-clock read latency |
| dq_o | output | DATA_W | Read data, zero when not enabled |
| dq_oe_o | output | 1 | Output enable; low means high impedance |

## Verification
Each kind of wrong internal state shows up at the ports within a few cycles:

- **Burst counter or column generator:** a wrong column shows as a wrong data word exactly L cycles after the slot that produced it. A wrong length shows as an enable that stays high, or drops early, on the cycle after the expected last word.
- **Latency pipeline:** a stale entry in a stage shows as a spurious enabled word after a WRITE or a terminating precharge, within the selected latency.
- **Mask delay:** a mask delay register that is off by one moves the gap in the enable to the neighbouring slot.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_PRE   = 2'd3
  } cmd_e;

  localparam logic [2:0] BLEN_2    = 3'd1;
  localparam logic [2:0] BLEN_4    = 3'd2;
  localparam logic [2:0] BLEN_8    = 3'd3;
  localparam logic [2:0] BLEN_PAGE = 3'd7;

  localparam int DQM_LAT = 2;

endpackage

// File: rtl/sdram_col_order.sv
module sdram_col_order #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] base;
  logic [COL_W-1:0] seq_off;
  logic [COL_W-1:0] ilv_off;

  assign base    = start_i & ~mask_i;
  assign seq_off = (start_i + idx_i) & mask_i;
  assign ilv_off = (start_i ^ idx_i) & mask_i;

  always_comb begin
    if (page_i)     col_o = start_i + idx_i;
    else if (ilv_i) col_o = base | ilv_off;
    else            col_o = base | seq_off;
  end

endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              all_banks_i,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  output logic              valid_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o
);

  logic              act_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  start_q, idx_q, mask_q, mask_d;
  logic              page_q, ilv_q;
  logic              pre_hit, last_word;

  always_comb begin
    case (burst_len_i)
      BLEN_2:  mask_d = COL_W'(1);
      BLEN_4:  mask_d = COL_W'(3);
      BLEN_8:  mask_d = COL_W'(7);
      default: mask_d = '0;
    endcase
  end

  assign pre_hit   = (cmd_i == CMD_PRE) && (all_banks_i || (bank_i == bank_q));
  assign last_word = !page_q && (idx_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      bank_q  <= '0;
      start_q <= '0;
      idx_q   <= '0;
      mask_q  <= '0;
      page_q  <= 1'b0;
      ilv_q   <= 1'b0;
    end else if (cmd_i == CMD_READ) begin
      act_q   <= 1'b1;
      bank_q  <= bank_i;
      start_q <= col_i;
      idx_q   <= '0;
      mask_q  <= mask_d;
      page_q  <= (burst_len_i == BLEN_PAGE);
      ilv_q   <= burst_type_i;
    end else if ((cmd_i == CMD_WRITE) || pre_hit) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (last_word) act_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  sdram_col_order #(.COL_W(COL_W)) u_order (
    .start_i (start_q),
    .idx_i   (idx_q),
    .mask_i  (mask_q),
    .page_i  (page_q),
    .ilv_i   (ilv_q),
    .col_o   (col_o)
  );

  assign valid_o = act_q;
  assign bank_o  = bank_q;

endmodule

// File: rtl/sdram_array_stub.sv
module sdram_array_stub #(
  parameter int                BANK_W = 2,
  parameter int                COL_W  = 8,
  parameter int                DATA_W = 16,
  parameter logic [DATA_W-1:0] SEED   = 16'hA5C3
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [DATA_W-1:0] data_o
);

  assign data_o = DATA_W'({bank_i, col_i}) ^ SEED;

endmodule

// File: rtl/sdram_lat_pipe.sv
module sdram_lat_pipe
  import sdram_rd_pkg::*;
#(
  parameter int                BANK_W = 2,
  parameter int                COL_W  = 8,
  parameter int                DATA_W = 16,
  parameter int                MAX_CL = 3,
  parameter logic [DATA_W-1:0] SEED   = 16'hA5C3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              dqm_i,
  input  logic [1:0]        cas_lat_i,
  input  logic              valid_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              oe_o
);

  localparam int SLOT_W = 1 + BANK_W + COL_W;

  logic [MAX_CL-1:0][SLOT_W-1:0] tap;
  logic [SLOT_W-1:0]             sel;
  logic [DQM_LAT-1:0]            dqm_q;
  logic [DATA_W-1:0]             word;
  logic                          drive;
  logic [DATA_W-1:0]             dq_q;
  logic                          oe_q;

  assign tap[0] = {valid_i, bank_i, col_i};

  // one register per extra latency cycle; a WRITE empties them
  for (genvar s = 1; s < MAX_CL; s++) begin : g_stage
    logic [SLOT_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (flush_i) q <= '0;
      else              q <= tap[s-1];
    end
    assign tap[s] = q;
  end

  always_comb begin
    int cl;
    cl = (cas_lat_i == 2'd0) ? 1 : int'(cas_lat_i);
    if (cl > MAX_CL) cl = MAX_CL;
    sel = '0;
    for (int s = 0; s < MAX_CL; s++) begin
      if (s == cl - 1) sel = tap[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dqm_q <= '0;
    else         dqm_q <= {dqm_q[DQM_LAT-2:0], dqm_i};
  end

  sdram_array_stub #(
    .BANK_W (BANK_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .SEED   (SEED)
  ) u_array (
    .bank_i (sel[COL_W +: BANK_W]),
    .col_i  (sel[COL_W-1:0]),
    .data_o (word)
  );

  assign drive = !flush_i && sel[SLOT_W-1] && !dqm_q[DQM_LAT-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q <= 1'b0;
      dq_q <= '0;
    end else begin
      oe_q <= drive;
      dq_q <= drive ? word : '0;
    end
  end

  assign dq_o = dq_q;
  assign oe_o = oe_q;

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
  import sdram_rd_pkg::*;
#(
  parameter int                DATA_W = 16,
  parameter int                BANK_W = 2,
  parameter int                COL_W  = 8,
  parameter int                MAX_CL = 3,
  parameter logic [DATA_W-1:0] SEED   = 16'hA5C3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              all_banks_i,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [1:0]        cas_lat_i,
  input  logic              dqm_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);

  cmd_e              cmd;
  logic              slot_v;
  logic [BANK_W-1:0] slot_bank;
  logic [COL_W-1:0]  slot_col;

  assign cmd = cmd_e'(cmd_i);

  sdram_burst_gen #(
    .BANK_W (BANK_W),
    .COL_W  (COL_W)
  ) u_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd),
    .bank_i       (bank_i),
    .col_i        (col_i),
    .all_banks_i  (all_banks_i),
    .burst_len_i  (burst_len_i),
    .burst_type_i (burst_type_i),
    .valid_o      (slot_v),
    .bank_o       (slot_bank),
    .col_o        (slot_col)
  );

  sdram_lat_pipe #(
    .BANK_W (BANK_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .MAX_CL (MAX_CL),
    .SEED   (SEED)
  ) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (cmd == CMD_WRITE),
    .dqm_i     (dqm_i),
    .cas_lat_i (cas_lat_i),
    .valid_i   (slot_v),
    .bank_i    (slot_bank),
    .col_i     (slot_col),
    .dq_o      (dq_o),
    .oe_o      (dq_oe_o)
  );

endmodule

// File: rtl/sdram_rd_pipe_chk.sv
module sdram_rd_pipe_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        cmd_i,
  input logic              all_banks_i,
  input logic [2:0]        burst_len_i,
  input logic [1:0]        cas_lat_i,
  input logic              dqm_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o
);

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!dq_oe_o && dq_o == '0)
        else $error("outputs active in reset");
    end
  end

  p_hiz_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> dq_o == '0);

  p_single_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd1 && burst_len_i == 3'd0 && cas_lat_i <= 2'd1) ##1 (cmd_i == 2'd0)
      |=> ##1 !dq_oe_o);

  p_dqm_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_i |-> ##3 !dq_oe_o);

  p_pre_all_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd3 && all_banks_i && cas_lat_i == 2'd1) |=> ##1 !dq_oe_o);

  p_write_kill_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd2) |=> !dq_oe_o);

endmodule

bind sdram_rd_pipe sdram_rd_pipe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_i       (cmd_i),
  .all_banks_i (all_banks_i),
  .burst_len_i (burst_len_i),
  .cas_lat_i   (cas_lat_i),
  .dqm_i       (dqm_i),
  .dq_o        (dq_o),
  .dq_oe_o     (dq_oe_o)
);

// File: tb/sdram_rd_pipe_tb_top.sv
`timescale 1ns/1ps
module sdram_rd_pipe_tb_top;

  localparam logic [15:0] SEED = 16'hA5C3;
  localparam logic [1:0] NOP = 2'd0, RD = 2'd1, WR = 2'd2, PRE = 2'd3;

  typedef struct packed {
    logic [2:0] bl;
    logic       bt;
    logic [1:0] cl;
    logic [1:0] bank;
    logic [7:0] col;
    logic [3:0] nw;
    logic [7:0] last;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{3'd2, 1'b0, 2'd1, 2'd1, 8'h05, 4'd4, 8'h04},
    '{3'd2, 1'b1, 2'd2, 2'd2, 8'h05, 4'd4, 8'h06},
    '{3'd3, 1'b0, 2'd3, 2'd0, 8'h1D, 4'd8, 8'h1C},
    '{3'd3, 1'b1, 2'd1, 2'd3, 8'h1D, 4'd8, 8'h1A},
    '{3'd0, 1'b0, 2'd2, 2'd1, 8'h33, 4'd1, 8'h33},
    '{3'd1, 1'b1, 2'd3, 2'd2, 8'h41, 4'd2, 8'h40},
    '{3'd1, 1'b0, 2'd1, 2'd0, 8'hFF, 4'd2, 8'hFE},
    '{3'd4, 1'b0, 2'd0, 2'd3, 8'h10, 4'd1, 8'h10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [1:0]  cmd = NOP;
  logic [1:0]  bank = '0;
  logic [7:0]  col = '0;
  logic        all_banks = 1'b0;
  logic [2:0]  bl = '0;
  logic        bt = 1'b0;
  logic [1:0]  cl = 2'd1;
  logic        dqm = 1'b0;
  logic [15:0] dq;
  logic        oe;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sdram_rd_pipe dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmd_i        (cmd),
    .bank_i       (bank),
    .col_i        (col),
    .all_banks_i  (all_banks),
    .burst_len_i  (bl),
    .burst_type_i (bt),
    .cas_lat_i    (cl),
    .dqm_i        (dqm),
    .dq_o         (dq),
    .dq_oe_o      (oe)
  );

  task automatic chk(input string req, input logic exp_oe, input logic [1:0] b,
                     input logic [7:0] c);
    logic [15:0] exp_dq;
    exp_dq = exp_oe ? (16'({b, c}) ^ SEED) : 16'h0000;
    total++;
    if (oe !== exp_oe || dq !== exp_dq) begin
      bad++;
      $display("FAIL %s: oe=%0b dq=%h expected oe=%0b dq=%h", req, oe, dq, exp_oe, exp_dq);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [2:0] len, input logic ilv,
                                         input logic [7:0] st, input int i);
    int n, base, off;
    case (len)
      3'd1: n = 2;
      3'd2: n = 4;
      3'd3: n = 8;
      3'd7: n = 256;
      default: n = 1;
    endcase
    if (n == 256) return 8'((int'(st) + i) % 256);
    base = (int'(st) / n) * n;
    off  = int'(st) % n;
    off  = ilv ? (off ^ i) : ((off + i) % n);
    return 8'(base + off);
  endfunction

  // R11: enable must be low on any cycle that presents a WRITE
  always @(posedge clk) begin
    if (rst_n && cmd == WR) begin
      total++;
      if (oe) begin
        bad++;
        $display("FAIL R11: oe=1 dq=%h expected oe=0 on WRITE cycle", dq);
      end
    end
  end

  task automatic idle(input int n);
    cmd = NOP; dqm = 1'b0; all_banks = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    cmd = RD; bank = 2'd1; col = 8'h22;
    repeat (3) @(negedge clk);
    chk("R1 reset", 1'b0, 2'd0, 8'h00);
    cmd = NOP;
    @(negedge clk);
    chk("R1 reset", 1'b0, 2'd0, 8'h00);
    rst_n = 1'b1;
    idle(2);
    chk("R1 after reset", 1'b0, 2'd0, 8'h00);

    // table: R2 R3 R4 R5 R6
    foreach (VECS[v]) begin
      vec_t e;
      int lat;
      string tag;
      e = VECS[v];
      lat = (e.cl == 2'd0) ? 1 : int'(e.cl);
      tag = e.bt ? "R2 R3 R6" : "R2 R3 R5";
      if (e.bl == 3'd4) tag = "R4 reserved length";
      bl = e.bl; bt = e.bt; cl = e.cl;
      @(negedge clk);
      cmd = RD; bank = e.bank; col = e.col;
      @(negedge clk);
      cmd = NOP;
      repeat (lat) @(negedge clk);
      for (int i = 0; i < int'(e.nw); i++) begin
        if (i > 0) @(negedge clk);
        chk(tag, 1'b1, e.bank,
            (i == int'(e.nw) - 1) ? e.last : exp_col(e.bl, e.bt, e.col, i));
      end
      @(negedge clk);
      chk("R4 burst end", 1'b0, 2'd0, 8'h00);
      idle(3);
    end

    // R7 full page wrap, R10 precharge-all stop, CL1
    bl = 3'd7; bt = 1'b1; cl = 2'd1;
    @(negedge clk);
    cmd = RD; bank = 2'd1; col = 8'hFE;
    @(negedge clk);
    for (int t = 0; t <= 9; t++) begin
      if (t > 0) begin
        if (t >= 1 && t <= 6) chk("R7 page wrap", 1'b1, 2'd1, 8'(8'hFE + t - 1));
        else                  chk("R10 precharge all", 1'b0, 2'd0, 8'h00);
      end
      cmd = (t + 1 == 6) ? PRE : NOP;
      all_banks = (t + 1 == 6);
      @(negedge clk);
    end
    idle(3);

    // R10 other bank ignored, own bank stops, CL2
    bl = 3'd7; bt = 1'b0; cl = 2'd2;
    @(negedge clk);
    cmd = RD; bank = 2'd2; col = 8'h10;
    @(negedge clk);
    for (int t = 0; t <= 9; t++) begin
      if (t > 0) begin
        if (t >= 2 && t <= 6) chk("R10 bank match", 1'b1, 2'd2, 8'(8'h10 + t - 2));
        else                  chk("R10 bank match", 1'b0, 2'd0, 8'h00);
      end
      cmd = NOP; bank = 2'd2;
      if (t + 1 == 3) begin cmd = PRE; bank = 2'd1; end
      if (t + 1 == 5) begin cmd = PRE; bank = 2'd2; end
      @(negedge clk);
    end
    idle(3);

    // R9 read interrupts read on the next cycle, CL3
    bl = 3'd2; bt = 1'b0; cl = 2'd3;
    @(negedge clk);
    cmd = RD; bank = 2'd0; col = 8'h20;
    @(negedge clk);
    for (int t = 0; t <= 9; t++) begin
      if (t > 0) begin
        if (t == 3)                chk("R9 old word", 1'b1, 2'd0, 8'h20);
        else if (t >= 4 && t <= 7) chk("R9 new burst", 1'b1, 2'd1, 8'(8'h44 + t - 4));
        else                       chk("R9 end", 1'b0, 2'd0, 8'h00);
      end
      cmd = NOP;
      if (t == 0) begin cmd = RD; bank = 2'd1; col = 8'h44; end
      @(negedge clk);
    end
    idle(3);

    // R9 later interrupt, CL1, wrap inside 8-block
    bl = 3'd3; bt = 1'b0; cl = 2'd1;
    @(negedge clk);
    cmd = RD; bank = 2'd3; col = 8'h08;
    @(negedge clk);
    for (int t = 0; t <= 13; t++) begin
      if (t > 0) begin
        if (t <= 3)       chk("R9 old words", 1'b1, 2'd3, 8'(8'h08 + t - 1));
        else if (t <= 11) chk("R9 R5 new burst", 1'b1, 2'd0, exp_col(3'd3, 1'b0, 8'h32, t - 4));
        else              chk("R9 end", 1'b0, 2'd0, 8'h00);
      end
      cmd = NOP;
      if (t + 1 == 3) begin cmd = RD; bank = 2'd0; col = 8'h32; end
      @(negedge clk);
    end
    idle(3);

    // R8 DQM two-clock latency, CL2
    bl = 3'd3; bt = 1'b0; cl = 2'd2;
    @(negedge clk);
    cmd = RD; bank = 2'd1; col = 8'h50;
    @(negedge clk);
    cmd = NOP;
    for (int t = 0; t <= 11; t++) begin
      if (t > 0) begin
        if (t >= 2 && t <= 9 && t != 5) chk("R8 unmasked", 1'b1, 2'd1, 8'(8'h50 + t - 2));
        else                            chk("R8 masked", 1'b0, 2'd0, 8'h00);
      end
      dqm = (t == 2);
      @(negedge clk);
    end
    idle(3);

    // R11 write kills burst; DQM keeps WRITE cycle quiet, CL3
    bl = 3'd3; bt = 1'b0; cl = 2'd3;
    @(negedge clk);
    cmd = RD; bank = 2'd2; col = 8'h60;
    @(negedge clk);
    for (int t = 0; t <= 11; t++) begin
      if (t > 0) begin
        if (t >= 3 && t <= 5) chk("R11 before write", 1'b1, 2'd2, 8'(8'h60 + t - 3));
        else if (t >= 6)      chk("R11 after write", 1'b0, 2'd0, 8'h00);
      end
      dqm = (t == 3 || t == 4);
      cmd = (t == 6) ? WR : NOP;
      @(negedge clk);
    end
    idle(3);
    chk("R11 stays idle", 1'b0, 2'd0, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule